// File: doc/BRIEF.md
# Oscilloscope Capture Sequencer

This block runs one acquisition cycle of a sampling front end. A host arms it with a trigger position. The block then records a chosen number of samples taken before the trigger into a circular sample memory. Once that history is full it keeps overwriting it while it waits for a trigger event, either a real one or a forced one. It then records the remaining samples after the trigger and stops. Each stored entry packs two 10-bit analog readings, eight logic-analyser bits and one bus-activity bit into a 32-bit word.

After capture the host selects read mode and pulls the record out one byte at a time, four bytes per stored entry. The entries come out starting from the oldest. A 4-bit status code follows the sequence at every step, and the host polls it to learn when to trigger, when to read and when the read is finished. Reset, arm and forced trigger each arrive as single-cycle command pulses.

Top module: `scope_capture_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after a `cmd_reset` pulse in any state, status reads 0 (idle-reset). One cycle later it reads 1 (waiting for arm).
- R2: With status 1, a `cmd_arm` pulse moves status to 2 (armed) for exactly one cycle, and then to 3 (pretrigger filling).
- R3: While status is 2 the block latches the pretrigger count P = min(`trig_pos`, DEPTH). Status 3 holds until P samples have been written and reads 4 (waiting for trigger) in the cycle after the P-th write. If P is 0, status shows 3 for one cycle and then 4.
- R4: A `trig_event` or `cmd_force` pulse while status is 3 is ignored. Status stays 3, and the pretrigger count and the recorded data are unchanged.
- R5: With status 4, samples keep being written and overwrite the oldest ones circularly. A `trig_event` pulse or a `cmd_force` pulse moves status to 5 (post-trigger filling) in the next cycle, and the two pulses behave identically.
- R6: The post-trigger count is DEPTH − P. Status reads 6 (capture complete) in the cycle after the last post-trigger write. If the count is 0, status shows 5 for one cycle and then 6.
- R7: Status 6 holds for as long as `read_mode` is low. Raising `read_mode` moves status to 7 (reading).
- R8: In status 7, reading returns the last DEPTH samples written, oldest first. Each fourth `byte_rd` pulse advances to the next entry. Byte reads may be back to back or spaced apart.
- R9: A stored word is {3'b000, `usb_in`, `logic_in`, `ch_b`, `ch_a`}, with `ch_a` at bits 9:0. The k-th byte read of an entry (k = 0..3) is word bits 8k+7:8k. It appears on `rd_byte` in the cycle after the `byte_rd` pulse and holds until the next pulse.
- R10: The cycle after the 4·DEPTH-th byte read, status reads 8 (read finished). With status 8, a low `read_mode` returns status to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_reset | input | 1 | Single-cycle sequencer reset command |
| cmd_arm | input | 1 | Single-cycle arm command |
| cmd_force | input | 1 | Single-cycle forced trigger command |
| trig_event | input | 1 | Trigger event from the trigger detector |
| trig_pos | input | POS_W | Pretrigger sample count request |
| sample_en | input | 1 | Sample strobe; one stored entry per high cycle |
| ch_a | input | ADC_W | Analog channel A reading |
| ch_b | input | ADC_W | Analog channel B reading |
| logic_in | input | LOGIC_W | Logic analyser inputs |
| usb_in | input | 1 | Bus activity bit |
| read_mode | input | 1 | Selects read-back of the captured record |
| byte_rd | input | 1 | Byte read strobe |
| rd_byte | output | BYTE_W | Registered read-back byte |
| status | output | 4 | Registered sequence status code |

## Verification
The bench builds the block with DEPTH set to 16, so every capture can be read back in full: all 64 bytes, compared against a history the bench keeps itself. That small depth allows a sweep of every trigger position from 0 through DEPTH+2, plus two large out-of-range positions. The sweep covers both empty-region corner cases, a varying number of wraparound writes while waiting for the trigger, alternating real and forced triggers, ignored early triggers, and reads both back to back and with gaps. Reset commands issued in the middle of a capture are checked too.

// File: rtl/scope_seq_pkg.sv
package scope_seq_pkg;

  typedef enum logic [3:0] {
    ST_RESET     = 4'd0,
    ST_WAIT_ARM  = 4'd1,
    ST_ARMED     = 4'd2,
    ST_PRE_FILL  = 4'd3,
    ST_WAIT_TRIG = 4'd4,
    ST_POST_FILL = 4'd5,
    ST_DONE      = 4'd6,
    ST_READING   = 4'd7,
    ST_END_READ  = 4'd8
  } cap_state_e;

endpackage

// File: rtl/scope_seq_ram.sv
module scope_seq_ram #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [0:WORDS-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/scope_seq_fill.sv
module scope_seq_fill #(
  parameter int DEPTH = 1024,
  parameter int POS_W = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [POS_W-1:0] trig_pos,
  input  logic             wr_en,
  input  logic             in_pre,
  input  logic             in_post,
  output logic [AW-1:0]    wr_ptr,
  output logic             pre_zero,
  output logic             pre_last,
  output logic             post_zero,
  output logic             post_last
);
  localparam logic [POS_W-1:0] DEPTH_P = POS_W'(DEPTH);

  logic [CW-1:0] pre_tgt, post_tgt, pre_cnt, post_cnt;
  logic [CW-1:0] clamp_c;

  assign clamp_c = (trig_pos >= DEPTH_P) ? CW'(DEPTH) : CW'(trig_pos);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_tgt  <= '0;
      post_tgt <= '0;
      pre_cnt  <= '0;
      post_cnt <= '0;
      wr_ptr   <= '0;
    end else if (load) begin
      pre_tgt  <= clamp_c;
      post_tgt <= CW'(DEPTH) - clamp_c;
      pre_cnt  <= '0;
      post_cnt <= '0;
      wr_ptr   <= '0;
    end else if (wr_en) begin
      wr_ptr <= wr_ptr + AW'(1);
      if (in_pre)  pre_cnt  <= pre_cnt + CW'(1);
      if (in_post) post_cnt <= post_cnt + CW'(1);
    end
  end

  assign pre_zero  = (pre_tgt == '0);
  assign post_zero = (post_tgt == '0);
  assign pre_last  = (pre_cnt + CW'(1) == pre_tgt);
  assign post_last = (post_cnt + CW'(1) == post_tgt);

  assert_pre_bound_R3: assert property (@(posedge clk) disable iff (rst)
    pre_cnt <= pre_tgt);

  assert_post_bound_R6: assert property (@(posedge clk) disable iff (rst)
    post_cnt <= post_tgt);

  assert_split_sum_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> (pre_tgt + post_tgt == CW'(DEPTH)));

endmodule

// File: rtl/scope_seq_reader.sv
module scope_seq_reader #(
  parameter int AW = 10,
  parameter int DW = 32,
  parameter int BW = 8,
  localparam int NB = DW / BW,
  localparam int SW = $clog2(NB)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] start_ptr,
  input  logic          rd_en,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] raddr,
  output logic [BW-1:0] rd_byte,
  output logic          last_byte
);
  logic [BW-1:0] lane [NB];
  logic [SW-1:0] byte_sel;
  logic [AW-1:0] rd_ptr;
  logic [AW-1:0] pos_cnt;
  logic          adv;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane[g] = rdata[g*BW +: BW];
  end

  assign adv       = rd_en && (byte_sel == SW'(NB - 1));
  assign last_byte = adv && (pos_cnt == {AW{1'b1}});
  assign raddr     = load ? start_ptr : (adv ? rd_ptr + AW'(1) : rd_ptr);

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_sel <= '0;
      rd_ptr   <= '0;
      pos_cnt  <= '0;
      rd_byte  <= '0;
    end else if (load) begin
      byte_sel <= '0;
      rd_ptr   <= start_ptr;
      pos_cnt  <= '0;
    end else if (rd_en) begin
      rd_byte  <= lane[byte_sel];
      byte_sel <= byte_sel + SW'(1);
      if (adv) begin
        rd_ptr  <= rd_ptr + AW'(1);
        pos_cnt <= pos_cnt + AW'(1);
      end
    end
  end

  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !load) |=> ($stable(rd_ptr) && $stable(byte_sel)));

  assert_byte_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_byte));

endmodule

// File: rtl/scope_capture_seq.sv
module scope_capture_seq
  import scope_seq_pkg::*;
#(
  parameter int DEPTH    = 1024,
  parameter int POS_W    = 16,
  parameter int ADC_W    = 10,
  parameter int LOGIC_W  = 8,
  parameter int SAMPLE_W = 32,
  parameter int BYTE_W   = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_reset,
  input  logic               cmd_arm,
  input  logic               cmd_force,
  input  logic               trig_event,
  input  logic [POS_W-1:0]   trig_pos,
  input  logic               sample_en,
  input  logic [ADC_W-1:0]   ch_a,
  input  logic [ADC_W-1:0]   ch_b,
  input  logic [LOGIC_W-1:0] logic_in,
  input  logic               usb_in,
  input  logic               read_mode,
  input  logic               byte_rd,
  output logic [BYTE_W-1:0]  rd_byte,
  output logic [3:0]         status
);
  localparam int AW    = $clog2(DEPTH);
  localparam int PAD_W = SAMPLE_W - 2 * ADC_W - LOGIC_W - 1;

  cap_state_e state, nxt;

  logic [SAMPLE_W-1:0] sample_word;
  logic [SAMPLE_W-1:0] ram_q;
  logic [AW-1:0]       wr_ptr, ram_raddr;
  logic pre_zero, pre_last, post_zero, post_last;
  logic in_pre, in_post, wr_en, trig_any, rd_en, last_byte;

  assign sample_word = {{PAD_W{1'b0}}, usb_in, logic_in, ch_b, ch_a};
  assign in_pre      = (state == ST_PRE_FILL);
  assign in_post     = (state == ST_POST_FILL);
  assign trig_any    = trig_event | cmd_force;
  assign rd_en       = byte_rd && (state == ST_READING);
  assign wr_en       = sample_en && ((in_pre && !pre_zero) ||
                                     (state == ST_WAIT_TRIG) ||
                                     (in_post && !post_zero));

  always_comb begin
    nxt = state;
    unique case (state)
      ST_RESET:     nxt = ST_WAIT_ARM;
      ST_WAIT_ARM:  if (cmd_arm) nxt = ST_ARMED;
      ST_ARMED:     nxt = ST_PRE_FILL;
      ST_PRE_FILL:  if (pre_zero || (sample_en && pre_last)) nxt = ST_WAIT_TRIG;
      ST_WAIT_TRIG: if (trig_any) nxt = ST_POST_FILL;
      ST_POST_FILL: if (post_zero || (sample_en && post_last)) nxt = ST_DONE;
      ST_DONE:      if (read_mode) nxt = ST_READING;
      ST_READING:   if (last_byte) nxt = ST_END_READ;
      ST_END_READ:  if (!read_mode) nxt = ST_WAIT_ARM;
      default:      nxt = ST_RESET;
    endcase
    if (cmd_reset) nxt = ST_RESET;
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RESET;
    else     state <= nxt;
  end

  assign status = state;

  scope_seq_fill #(.DEPTH(DEPTH), .POS_W(POS_W)) u_fill (
    .clk       (clk),
    .rst       (rst),
    .load      (state == ST_ARMED),
    .trig_pos  (trig_pos),
    .wr_en     (wr_en),
    .in_pre    (in_pre),
    .in_post   (in_post),
    .wr_ptr    (wr_ptr),
    .pre_zero  (pre_zero),
    .pre_last  (pre_last),
    .post_zero (post_zero),
    .post_last (post_last)
  );

  scope_seq_ram #(.AW(AW), .DW(SAMPLE_W)) u_ram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_ptr),
    .wdata (sample_word),
    .raddr (ram_raddr),
    .rdata (ram_q)
  );

  scope_seq_reader #(.AW(AW), .DW(SAMPLE_W), .BW(BYTE_W)) u_reader (
    .clk       (clk),
    .rst       (rst),
    .load      (state == ST_DONE),
    .start_ptr (wr_ptr),
    .rd_en     (rd_en),
    .rdata     (ram_q),
    .raddr     (ram_raddr),
    .rd_byte   (rd_byte),
    .last_byte (last_byte)
  );

  assert_cmd_reset_R1: assert property (@(posedge clk) disable iff (rst)
    cmd_reset |=> (state == ST_RESET));

  assert_reset_exit_R1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RESET && !cmd_reset) |=> (state == ST_WAIT_ARM));

  assert_armed_once_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED && !cmd_reset) |=> (state == ST_PRE_FILL));

  assert_no_early_trig_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PRE_FILL && !cmd_reset) |=>
      (state == ST_PRE_FILL || state == ST_WAIT_TRIG));

  assert_trig_moves_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_TRIG && trig_any && !cmd_reset) |=> (state == ST_POST_FILL));

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && !read_mode && !cmd_reset) |=> (state == ST_DONE));

  initial begin
    assert_layout_R9: assert (PAD_W >= 0 && (DEPTH & (DEPTH - 1)) == 0);
  end

endmodule

// File: tb/scope_capture_seq_test.sv
module scope_capture_seq_test;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_reset = 1'b0, cmd_arm = 1'b0, cmd_force = 1'b0, trig_event = 1'b0;
  logic [15:0] trig_pos = '0;
  logic sample_en = 1'b0;
  logic [9:0] ch_a = '0, ch_b = '0;
  logic [7:0] logic_in = '0;
  logic usb_in = 1'b0;
  logic read_mode = 1'b0;
  logic byte_rd = 1'b0;
  logic [7:0] rd_byte;
  logic [3:0] status;

  int n_checks = 0;
  int n_fail = 0;
  logic [31:0] hist [0:255];
  int nh = 0;
  int seq = 0;

  always #2 clk = ~clk;

  scope_capture_seq #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .cmd_reset(cmd_reset), .cmd_arm(cmd_arm),
    .cmd_force(cmd_force), .trig_event(trig_event), .trig_pos(trig_pos),
    .sample_en(sample_en), .ch_a(ch_a), .ch_b(ch_b), .logic_in(logic_in),
    .usb_in(usb_in), .read_mode(read_mode), .byte_rd(byte_rd),
    .rd_byte(rd_byte), .status(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_status(input string req, input int exp);
    chk(int'(status) == exp, req, int'(status), exp);
  endtask

  function automatic logic [31:0] word_of(input int n);
    logic [9:0] a, b;
    logic [7:0] l;
    a = 10'((n * 37 + 5) & 1023);
    b = 10'(((n * 53) ^ 341) & 1023);
    l = 8'((n * 29 + 3) & 255);
    return {3'b000, 1'(n & 1), l, b, a};
  endfunction

  task automatic push();
    logic [31:0] w;
    w = word_of(seq);
    seq++;
    ch_a = w[9:0];
    ch_b = w[19:10];
    logic_in = w[27:20];
    usb_in = w[28];
    sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
    hist[nh] = w;
    nh++;
  endtask

  task automatic arm(input int tp);
    trig_pos = 16'(tp);
    cmd_arm = 1'b1;
    @(negedge clk);
    cmd_arm = 1'b0;
    chk_status("R2 armed", 2);
    @(negedge clk);
    chk_status("R3 pretrigger fill", 3);
  endtask

  task automatic read_all(input bit gaps);
    read_mode = 1'b1;
    @(negedge clk);
    chk_status("R7 reading", 7);
    for (int p = 0; p < DEPTH; p++) begin
      for (int b = 0; b < 4; b++) begin
        logic [31:0] w;
        byte_rd = 1'b1;
        @(negedge clk);
        w = hist[nh - DEPTH + p];
        chk(rd_byte == w[8*b +: 8], "R8 R9 byte", int'(rd_byte), int'(w[8*b +: 8]));
        if (gaps) begin
          byte_rd = 1'b0;
          @(negedge clk);
          chk(rd_byte == w[8*b +: 8], "R9 hold", int'(rd_byte), int'(w[8*b +: 8]));
        end
        if (p == DEPTH / 2 && b == 0) chk_status("R10 mid read", 7);
      end
    end
    byte_rd = 1'b0;
    chk_status("R10 read end", 8);
    @(negedge clk);
    chk_status("R10 hold end", 8);
    read_mode = 1'b0;
    @(negedge clk);
    chk_status("R10 back to wait", 1);
  endtask

  task automatic run(input int tp, input int extra, input bit early, input bit use_force, input bit gaps);
    int pre, post;
    pre = (tp >= DEPTH) ? DEPTH : tp;
    post = DEPTH - pre;
    nh = 0;
    chk_status("R2 waiting", 1);
    arm(tp);
    if (pre == 0) begin
      @(negedge clk);
      chk_status("R3 empty pretrigger", 4);
    end
    for (int i = 0; i < pre; i++) begin
      if (early && i == pre / 2) begin
        trig_event = 1'b1;
        cmd_force = 1'b1;
        @(negedge clk);
        trig_event = 1'b0;
        cmd_force = 1'b0;
        @(negedge clk);
        chk_status("R4 early trigger", 3);
      end
      push();
      chk_status("R3 pretrigger", (i == pre - 1) ? 4 : 3);
    end
    for (int e = 0; e < extra; e++) begin
      push();
      chk_status("R5 waiting wrap", 4);
    end
    if (use_force) cmd_force = 1'b1;
    else trig_event = 1'b1;
    @(negedge clk);
    cmd_force = 1'b0;
    trig_event = 1'b0;
    chk_status("R5 triggered", 5);
    if (post == 0) begin
      @(negedge clk);
      chk_status("R6 empty post", 6);
    end
    for (int i = 0; i < post; i++) begin
      push();
      chk_status("R6 post fill", (i == post - 1) ? 6 : 5);
    end
    repeat (3) @(negedge clk);
    chk_status("R7 done hold", 6);
    read_all(gaps);
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  initial begin
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk_status("R1 in reset", 0);
    rst = 1'b0;
    @(negedge clk);
    chk_status("R1 after reset", 1);

    for (int tp = 0; tp <= DEPTH + 2; tp++)
      run(tp, tp % 4, (tp >= 2) && (tp % 3 == 0), tp % 2 == 1, tp % 5 == 2);
    run(16'hFFFF, 2, 1'b1, 1'b0, 1'b0);
    run(16'h0100, 0, 1'b0, 1'b1, 1'b0);

    // R1 reset command while waiting for trigger
    arm(5);
    nh = 0;
    for (int i = 0; i < 5; i++) push();
    chk_status("R3 before abort", 4);
    cmd_reset = 1'b1;
    @(negedge clk);
    cmd_reset = 1'b0;
    chk_status("R1 abort reset", 0);
    @(negedge clk);
    chk_status("R1 abort wait", 1);

    // R1 reset command during pretrigger fill
    arm(9);
    push();
    cmd_reset = 1'b1;
    @(negedge clk);
    cmd_reset = 1'b0;
    chk_status("R1 reset in fill", 0);
    @(negedge clk);
    chk_status("R1 recover", 1);

    run(7, 5, 1'b1, 1'b0, 1'b1);
    finish_up();
  end

endmodule